// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a clocked host to a 256K x 16 asynchronous static RAM. The host sees a simple request/ready handshake. Each request carries an 18-bit word address, a read/write flag, 16 bits of write data and one enable bit per byte lane. The controller turns each request into a correctly shaped asynchronous bus cycle. That cycle covers the address, two chip selects of opposite polarity, output enable, write enable and one active-low select per byte lane. The data bus is split into an output value, a drive enable and an input value, so that a pad ring or a tristate buffer at a higher level can join them.

Each asynchronous timing limit is a parameter in picoseconds. The controller converts it into a whole number of clock ticks by rounding up against the clock period. For a read, the controller holds the address and selects with output enable low for the access time, then registers the data at the end of that window. It gives back a one-cycle read-valid pulse in the same cycle that ready returns. For a write, the address and lane selects settle for a set number of clocks before write enable falls. The write data is driven only while write enable is low. The address stays fixed for at least one clock after write enable rises. The controller holds off any drive of the data bus until the memory's outputs have had time to float after output enable rose.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no request is in progress, `req_ready` is 1, the memory is in standby (`mem_cs_n`=1, `mem_cs`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_bs_n`=2'b11 and `mem_dq_oe`=0.
- R2: The memory is selected (`mem_cs_n`=0 and `mem_cs`=1) whenever write enable is low, and output enable and write enable are never low at the same time.
- R3: A read keeps output enable low for at least ceil(max(55 ns, 35 ns, 55 ns) / clock period) cycles. With the 10 ns default that is 6 cycles. `rd_valid` pulses for exactly one cycle, together with `req_ready`, 7 cycles after the request is accepted.
- R4: Bit 0 of `req_be` and of `mem_bs_n` govern data bits 7:0, and bit 1 governs bits 15:8. A lane is selected (its `mem_bs_n` bit is 0) only if its enable bit is 1. On a read, a lane that is not enabled returns 0 in `rd_data`.
- R5: Write enable falls only after the address, lane selects and chip selects have been stable for at least one clock. It stays low for at least 40 ns and at least 50 ns after the address became valid. The address does not change while write enable is low, nor in the cycle after write enable rises.
- R6: Write data is driven (`mem_dq_oe`=1) only while write enable is low. It is unchanged for at least 25 ns before write enable rises, and the drive is released on the same edge on which write enable rises.
- R7: The controller never drives the data bus while output enable is low. It starts driving no sooner than 20 ns after output enable last rose.
- R8: A write changes only the lanes whose enable bit is 1. A write with `req_be`=2'b00 leaves the addressed word unchanged.
- R9: A request is taken only while `req_ready` is 1. Every read or write bus cycle lasts at least 55 ns from acceptance to the return of `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane enables, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle pulse, read data present |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bs_n | output | 2 | Active-low lane selects, bit 0 = bits 7:0 |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The bench builds the controller with its default parameters: a 10 ns clock and the fast-grade limits. These give a six-cycle read access, a four-cycle write pulse and a two-tick float window after output enable rises. At that clock, a write issued right after a read arrives while the float window is still open, so the turnaround hold-off is exercised. The two extreme addresses are used, and single-lane and empty enable patterns are applied. Random requests are mixed with these directed cases. A sparse behavioural memory with per-lane semantics answers the bus, and a monitor measures pulse widths, data setup and drive gaps in clock ticks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WSET = 3'd2,
      ST_WPUL = 3'd3,
      ST_WREC = 3'd4
   } ctl_state_e;

   // Round a picosecond limit up to whole clock ticks, never below one.
   function automatic int unsigned ps_to_ticks(input int unsigned lim_ps,
                                               input int unsigned clk_ps);
      int unsigned t;
      t = (lim_ps + clk_ps - 1) / clk_ps;
      return (t == 0) ? 1 : t;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

   // The phase counter never wraps: it stays at zero once it gets there.
   p_timer_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));

endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [LANES-1:0]  acc_be,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic              sel_clr,
   input  logic              drive_on,
   input  logic              drive_off,
   input  logic              capture,
   input  logic [DATA_W-1:0] dq_i,
   output logic [LANES-1:0]  bs_n,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rd_data
);

   localparam int LANE_W = DATA_W / LANES;

   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         be_q    <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         be_q    <= acc_be;
         wdata_q <= acc_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_oe <= 1'b0;
         dq_o  <= '0;
      end else if (drive_off) begin
         dq_oe <= 1'b0;
      end else if (drive_on) begin
         dq_oe <= 1'b1;
         dq_o  <= wdata_q;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bs_n[l] <= 1'b1;
         else if (accept)
            bs_n[l] <= ~acc_be[l];
         else if (sel_clr)
            bs_n[l] <= 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_data[l*LANE_W +: LANE_W] <= '0;
         else if (capture)
            rd_data[l*LANE_W +: LANE_W] <= be_q[l] ? dq_i[l*LANE_W +: LANE_W]
                                                   : {LANE_W{1'b0}};
      end
   end

   // Driven write data holds still for the whole drive window.
   p_dq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

   // Lane selects change only while the bus is not being driven.
   p_bs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $stable(bs_n));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int          ADDR_W    = 18,
   parameter int          DATA_W    = 16,
   parameter int unsigned CLK_PS    = 10000,
   parameter int unsigned T_CYC_PS  = 55000,
   parameter int unsigned T_ACC_PS  = 55000,
   parameter int unsigned T_OEA_PS  = 35000,
   parameter int unsigned T_WPW_PS  = 40000,
   parameter int unsigned T_AEW_PS  = 50000,
   parameter int unsigned T_DSU_PS  = 25000,
   parameter int unsigned T_FLT_PS  = 20000,
   parameter int          SETUP_CYC = 1,
   parameter int          REC_CYC   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [DATA_W/8-1:0]  req_be,
   output logic                 rd_valid,
   output logic [DATA_W-1:0]    rd_data,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_cs_n,
   output logic                 mem_cs,
   output logic                 mem_oe_n,
   output logic                 mem_we_n,
   output logic [DATA_W/8-1:0]  mem_bs_n,
   output logic [DATA_W-1:0]    mem_dq_o,
   output logic                 mem_dq_oe,
   input  logic [DATA_W-1:0]    mem_dq_i
);

   localparam int          LANES  = DATA_W / 8;
   localparam int unsigned N_CYC  = ps_to_ticks(T_CYC_PS, CLK_PS);
   localparam int unsigned N_RD   = umax(umax(ps_to_ticks(T_ACC_PS, CLK_PS),
                                              ps_to_ticks(T_OEA_PS, CLK_PS)), N_CYC);
   localparam int unsigned N_AEW  = ps_to_ticks(T_AEW_PS, CLK_PS);
   localparam int unsigned N_WP_A = umax(ps_to_ticks(T_WPW_PS, CLK_PS),
                                         ps_to_ticks(T_DSU_PS, CLK_PS));
   localparam int unsigned N_WP_B = (N_AEW > SETUP_CYC) ? N_AEW - SETUP_CYC : 1;
   localparam int unsigned N_WP_C = (N_CYC > SETUP_CYC + REC_CYC) ?
                                    N_CYC - SETUP_CYC - REC_CYC : 1;
   localparam int unsigned N_WP   = umax(umax(N_WP_A, N_WP_B), N_WP_C);
   localparam int unsigned N_FLT  = ps_to_ticks(T_FLT_PS, CLK_PS);
   localparam int unsigned N_BIG  = umax(umax(N_RD, N_WP), umax(SETUP_CYC, REC_CYC));
   localparam int          CNT_W  = $clog2(N_BIG + 1) + 1;
   localparam int          FLT_W  = $clog2(N_FLT + 1) + 1;

   // Elaboration-time parameter checks.
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_width
      $error("sram_lane_ctrl: DATA_W must be a positive multiple of 8");
   end
   if (SETUP_CYC < 1 || REC_CYC < 1) begin : g_bad_guard
      $error("sram_lane_ctrl: SETUP_CYC and REC_CYC must be at least 1");
   end
   if (CLK_PS == 0 || ADDR_W < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: CLK_PS and ADDR_W must be non-zero");
   end

   ctl_state_e        state_q;
   logic              phase_done;
   logic              phase_load;
   logic [CNT_W-1:0]  phase_val;
   logic [FLT_W-1:0]  flt_q;
   logic              accept, rd_end, wset_go, wpul_end, wrec_end;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign rd_end    = (state_q == ST_RD)   && phase_done;
   assign wset_go   = (state_q == ST_WSET) && phase_done && (flt_q == '0);
   assign wpul_end  = (state_q == ST_WPUL) && phase_done;
   assign wrec_end  = (state_q == ST_WREC) && phase_done;

   assign phase_load = accept || wset_go || wpul_end;

   always_comb begin
      phase_val = '0;
      if (accept)
         phase_val = req_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(N_RD - 1);
      else if (wset_go)
         phase_val = CNT_W'(N_WP - 1);
      else if (wpul_end)
         phase_val = CNT_W'(REC_CYC - 1);
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_load),
      .load_val (phase_val),
      .done     (phase_done)
   );

   sram_lane_path #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .acc_be    (req_be),
      .acc_wdata (req_wdata),
      .sel_clr   (rd_end || wrec_end),
      .drive_on  (wset_go),
      .drive_off (wpul_end),
      .capture   (rd_end),
      .dq_i      (mem_dq_i),
      .bs_n      (mem_bs_n),
      .dq_o      (mem_dq_o),
      .dq_oe     (mem_dq_oe),
      .rd_data   (rd_data)
   );

   // Sequencer and the strobes it owns.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mem_addr <= '0;
         mem_cs_n <= 1'b1;
         mem_cs   <= 1'b0;
         mem_oe_n <= 1'b1;
         mem_we_n <= 1'b1;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               mem_addr <= req_addr;
               mem_cs_n <= 1'b0;
               mem_cs   <= 1'b1;
               mem_oe_n <= req_write;
               state_q  <= req_write ? ST_WSET : ST_RD;
            end
            ST_RD: if (rd_end) begin
               mem_oe_n <= 1'b1;
               mem_cs_n <= 1'b1;
               mem_cs   <= 1'b0;
               rd_valid <= 1'b1;
               state_q  <= ST_IDLE;
            end
            ST_WSET: if (wset_go) begin
               mem_we_n <= 1'b0;
               state_q  <= ST_WPUL;
            end
            ST_WPUL: if (wpul_end) begin
               mem_we_n <= 1'b1;
               state_q  <= ST_WREC;
            end
            ST_WREC: if (wrec_end) begin
               mem_cs_n <= 1'b1;
               mem_cs   <= 1'b0;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Float window after output enable rises; the bus is not driven until it expires.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flt_q <= '0;
      else if (rd_end)
         flt_q <= FLT_W'(N_FLT);
      else if (flt_q != '0)
         flt_q <= flt_q - 1'b1;
   end

   p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

   p_we_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_cs));

   p_oe_we_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   p_rdv_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (req_ready && !$past(rd_valid)));

   p_we_settled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_bs_n) && $stable(mem_cs_n)));

   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || $rose(mem_we_n)) |-> $stable(mem_addr));

   p_drive_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_oe);

   p_no_drive_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   p_busy_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> !mem_cs_n);

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;

   localparam int CLK_NS  = 10;
   localparam int RD_ACC  = (55 + CLK_NS - 1) / CLK_NS;   // output enable low window
   localparam int RD_LAT  = RD_ACC + 1;                   // negedges from accept to pulse

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [17:0] mem_addr;
   logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n;
   logic [1:0]  mem_bs_n;
   logic [15:0] mem_dq_o;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_i = '0;

   int n_checks = 0;
   int n_fails  = 0;
   bit done_run = 0;

   logic [15:0] mdl    [logic [17:0]];
   logic [15:0] shadow [logic [17:0]];

   always #(CLK_NS/2) clk = ~clk;

   sram_lane_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] lane_mask(input logic [1:0] be);
      return {{8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [15:0] sh_get(input logic [17:0] a);
      return shadow.exists(a) ? shadow[a] : 16'h0000;
   endfunction

   // Behavioural memory and bus monitor, both sampled on the falling edge.
   int          we_lo = 0, oe_lo = 0, oe_hi = 100, dq_stab = 0, addr_age = 0;
   logic [17:0] w_addr, prev_addr;
   logic [15:0] w_data, prev_dq;
   logic [1:0]  w_bs;
   logic        prev_oe_drv = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic sel;
         logic [15:0] cur;
         sel = !mem_cs_n && mem_cs;
         addr_age = (mem_addr == prev_addr) ? addr_age + 1 : 1;
         if (!mem_oe_n && !mem_we_n) check(0, "R2 oe and we both low", 0, 1);
         if (!mem_we_n) begin
            if (we_lo == 0) w_addr = mem_addr;
            if (mem_addr != w_addr) check(0, "R5 address moved during write", mem_addr, w_addr);
            if (!sel) check(0, "R2 write without select", {mem_cs_n, mem_cs}, 2'b01);
            dq_stab = (mem_dq_oe && mem_dq_o == prev_dq && dq_stab > 0) ? dq_stab + 1
                      : (mem_dq_oe ? 1 : 0);
            w_data = mem_dq_o;
            w_bs   = mem_bs_n;
            we_lo++;
         end else if (we_lo > 0) begin
            check(we_lo * CLK_NS >= 40, "R5 write pulse width", we_lo * CLK_NS, 40);
            check(addr_age * CLK_NS - CLK_NS >= 50, "R5 address to end of write",
                  addr_age * CLK_NS - CLK_NS, 50);
            check(mem_addr == w_addr, "R5 address held after write", mem_addr, w_addr);
            check(dq_stab * CLK_NS >= 25, "R6 data setup", dq_stab * CLK_NS, 25);
            check(!mem_dq_oe, "R6 drive released with write enable", mem_dq_oe, 0);
            cur = mdl.exists(w_addr) ? mdl[w_addr] : 16'h0000;
            if (!w_bs[0]) cur[7:0]  = w_data[7:0];
            if (!w_bs[1]) cur[15:8] = w_data[15:8];
            mdl[w_addr] = cur;
            we_lo = 0;
         end
         if (!mem_oe_n) begin
            if (mem_dq_oe) check(0, "R7 drive while output enable low", 1, 0);
            oe_lo++;
            oe_hi = 0;
         end else begin
            if (oe_lo > 0)
               check(oe_lo >= RD_ACC, "R3 output enable low window", oe_lo, RD_ACC);
            oe_lo = 0;
            if (oe_hi < 100) oe_hi++;
         end
         if (mem_dq_oe && !prev_oe_drv)
            check((oe_hi - 1) * CLK_NS >= 20, "R7 float gap before drive",
                  (oe_hi - 1) * CLK_NS, 20);
         prev_oe_drv = mem_dq_oe;
         prev_dq     = mem_dq_o;
         prev_addr   = mem_addr;
         // Model output, valid from the next falling edge.
         cur = mdl.exists(mem_addr) ? mdl[mem_addr] : 16'h0000;
         for (int l = 0; l < 2; l++)
            mem_dq_i[l*8 +: 8] <= (sel && mem_we_n && !mem_oe_n && !mem_bs_n[l]) ?
                                  cur[l*8 +: 8] : 8'h5A;
      end
   end

   task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
      int lat;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 0;
      lat = 1;
      while (!req_ready) begin @(negedge clk); lat++; end
      check((lat - 1) * CLK_NS >= 55, "R9 write cycle length", (lat - 1) * CLK_NS, 55);
      shadow[a] = (sh_get(a) & ~lane_mask(be)) | (d & lane_mask(be));
   endtask

   task automatic do_read(input logic [17:0] a, input logic [1:0] be, input string tag);
      int lat;
      logic [15:0] exp;
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = a; req_be = be;
      @(negedge clk);
      req_valid = 0;
      lat = 1;
      check(!req_ready, "R9 ready drops after accept", req_ready, 0);
      while (!rd_valid && lat < 50) begin @(negedge clk); lat++; end
      exp = sh_get(a) & lane_mask(be);
      check(lat == RD_LAT, "R3 read latency", lat, RD_LAT);
      check(req_ready, "R3 pulse with ready", req_ready, 1);
      check(rd_data == exp, tag, rd_data, exp);
      @(negedge clk);
      check(!rd_valid, "R3 pulse lasts one cycle", rd_valid, 0);
   endtask

   initial begin
      int cyc = 0;
      while (!done_run) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            check(0, "watchdog expired", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check(req_ready == 1, "R1 ready after reset", req_ready, 1);
      check({mem_cs_n, mem_cs} == 2'b10, "R1 standby after reset", {mem_cs_n, mem_cs}, 2'b10);
      check({mem_oe_n, mem_we_n} == 2'b11, "R1 strobes idle", {mem_oe_n, mem_we_n}, 2'b11);
      check(mem_bs_n == 2'b11, "R1 lanes idle", mem_bs_n, 2'b11);
      check(!mem_dq_oe && !rd_valid, "R1 no drive, no pulse", {mem_dq_oe, rd_valid}, 0);
      rst_n = 1;
      @(negedge clk);

      // R4 / R8 directed lane cases
      do_write(18'h00000, 16'hAA55, 2'b11);
      do_read (18'h00000, 2'b11, "R4 full word");
      do_write(18'h00000, 16'h1234, 2'b01);
      do_read (18'h00000, 2'b11, "R8 lower lane only written");
      do_write(18'h00000, 16'hBEEF, 2'b10);
      do_read (18'h00000, 2'b11, "R8 upper lane only written");
      do_write(18'h00000, 16'hFFFF, 2'b00);
      do_read (18'h00000, 2'b11, "R8 empty enables leave word");
      do_read (18'h00000, 2'b01, "R4 upper lane zero on read");
      do_read (18'h00000, 2'b10, "R4 lower lane zero on read");
      do_read (18'h00000, 2'b00, "R4 no lanes read zero");
      do_write(18'h3FFFF, 16'hC3A5, 2'b11);
      do_read (18'h3FFFF, 2'b11, "R4 top address");
      // R7 read immediately followed by a write
      do_read (18'h3FFFF, 2'b11, "R7 read before turnaround");
      do_write(18'h00001, 16'h0F0F, 2'b11);
      do_read (18'h00001, 2'b11, "R7 write after turnaround");
      check(mem_cs_n && !mem_cs, "R1 standby between requests", {mem_cs_n, mem_cs}, 2'b10);

      // Random mix over a small hot set plus scattered addresses.
      for (int i = 0; i < 400; i++) begin
         logic [17:0] a;
         a = ($urandom % 4 == 0) ? 18'($urandom) : 18'($urandom % 16);
         if ($urandom % 2)
            do_write(a, 16'($urandom), 2'($urandom));
         else
            do_read(a, 2'($urandom), "R4 random read");
      end

      repeat (4) @(negedge clk);
      done_run = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule